// File: doc/BRIEF.md
# DRAM Temperature Estimation Filter

This block keeps a running temperature estimate for each memory channel. The estimate is driven by memory activity. Each time a channel reports an energy delta, the old estimate is scaled down by a programmable decay factor. A programmable coefficient times the delta is then added. One 32-bit host configuration word holds both constants, and they apply to every channel and every DIMM.

A second host write path supplies measured temperatures for the four ranks of one DIMM. The DIMM is picked by an encoded channel index and an encoded DIMM index. The written values are stored and brought out per rank. The same write reseeds that channel's estimate with the hottest of the four ranks, and filtering then continues from that point. A write to a reserved index changes nothing and sets a sticky error flag.

Top module: `dram_temp_filter`

## Requirements
- R1: In the configuration word, the decay factor (beta) is bits 9:0 and the coefficient (theta) is bits 19:10. Bits 31:20 are ignored. `cfg_rdata` returns `{12'b0, theta, beta}` from the cycle after the write.
- R2: After reset, beta is 0x3FF, theta is 0, every channel estimate is 0, every stored rank temperature is 0, and `idx_err` is 0.
- R3: Each estimate is an unsigned degrees-Celsius value with 8 fractional bits, at `chan_est[16c+15:16c]`. When `egy_valid[c]` is high, the estimate becomes floor(beta*est/1024) + floor(theta*delta*256/1024). Here delta is `egy_delta[16c+15:16c]`.
- R4: The updated estimate saturates at 0xFFFF instead of wrapping.
- R5: A single beta/theta pair is used for all channels. Equal histories on different channels therefore give equal estimates.
- R6: A channel estimate holds its value in any cycle with neither an energy update nor a rank write for that channel.
- R7: A rank write carries rank 0 in `rank_wdata[7:0]` up to rank 3 in `rank_wdata[31:24]`, as unsigned degrees Celsius. The four bytes are stored at `rank_temp[32*(3*chan+dimm) +: 32]`.
- R8: A valid rank write loads that channel's estimate with the largest of the four bytes as its integer part and zero fraction. In the same cycle it wins over an energy update on that channel. Updates on other channels still proceed.
- R9: The index encodings 0, 1 and 2 select channel or DIMM 0, 1 and 2. Any index value of 3 or more is reserved. A write using a reserved index stores nothing, leaves every estimate alone, and sets `idx_err`. The flag stays set until reset.
- R10: An energy update in the same cycle as a configuration write uses the previous beta and theta.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word (beta, theta, reserved) |
| cfg_rdata | output | 32 | Current configuration, reserved bits zero |
| rank_we | input | 1 | Rank temperature write strobe |
| rank_chan | input | 3 | Encoded channel index |
| rank_dimm | input | 3 | Encoded DIMM index |
| rank_wdata | input | 32 | Four rank temperatures, one byte each |
| egy_valid | input | 3 | Per-channel energy delta valid |
| egy_delta | input | 48 | Per-channel 16-bit energy delta |
| chan_est | output | 48 | Per-channel estimate, 8.8 fixed point |
| rank_temp | output | 288 | Stored rank temperatures, 9 DIMM slots of 32 bits |
| idx_err | output | 1 | Sticky reserved-index flag |

## Verification
Two kinds of operation can land on one channel in the same cycle. One is an energy update and the other is a rank-temperature write. A configuration write can also coincide with an update. The bench drives a rank write to one channel while every channel has a valid delta. It expects the written channel to take the hottest rank value and the others to filter normally. It also changes beta and theta in a cycle that carries deltas and expects the old constants to apply. A behavioural model recomputes every estimate, stored rank word, readback and flag each clock and compares them all.

// File: rtl/dram_temp_filter.sv
module dram_temp_filter #(
  parameter int NCH   = 3,
  parameter int NDIMM = 3,
  parameter int NRANK = 4,
  parameter int TW    = 8,
  parameter int FRAC  = 8,
  parameter int EW    = 16,
  parameter int KW    = 10,
  parameter int IW    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [31:0]                 cfg_wdata,
  output logic [31:0]                 cfg_rdata,
  input  logic                        rank_we,
  input  logic [IW-1:0]               rank_chan,
  input  logic [IW-1:0]               rank_dimm,
  input  logic [NRANK*TW-1:0]         rank_wdata,
  input  logic [NCH-1:0]              egy_valid,
  input  logic [NCH*EW-1:0]           egy_delta,
  output logic [NCH*(TW+FRAC)-1:0]    chan_est,
  output logic [NCH*NDIMM*NRANK*TW-1:0] rank_temp,
  output logic                        idx_err
);
  localparam int SW = TW + FRAC;
  localparam int RW = NRANK * TW;
  localparam int PW = SW + KW;
  localparam int HW = EW + KW + FRAC;
  localparam int AW = ((HW > PW) ? HW : PW) + 1;
  localparam logic [IW-1:0] CH_LIM = IW'(NCH);
  localparam logic [IW-1:0] DM_LIM = IW'(NDIMM);

  logic [KW-1:0] beta_q, theta_q;
  logic          err_q;
  logic          idx_ok;
  logic [TW-1:0] hot;

  function automatic logic [TW-1:0] hottest(input logic [RW-1:0] v);
    logic [TW-1:0] m;
    m = v[TW-1:0];
    for (int r = 1; r < NRANK; r++)
      if (v[r*TW +: TW] > m) m = v[r*TW +: TW];
    return m;
  endfunction

  assign idx_ok    = (rank_chan < CH_LIM) && (rank_dimm < DM_LIM);
  assign hot       = hottest(rank_wdata);
  assign cfg_rdata = {{(32-2*KW){1'b0}}, theta_q, beta_q};
  assign idx_err   = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beta_q  <= '1;
      theta_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (cfg_we) begin
        beta_q  <= cfg_wdata[KW-1:0];
        theta_q <= cfg_wdata[2*KW-1:KW];
      end
      if (rank_we && !idx_ok) err_q <= 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SW-1:0] est_q;
    logic [EW-1:0] d;
    logic [AW-1:0] sum_w;
    logic [SW-1:0] nxt;
    logic          hit;

    assign d   = egy_delta[c*EW +: EW];
    assign hit = rank_we && idx_ok && (rank_chan == IW'(c));
    assign sum_w = AW'(({{KW{1'b0}}, est_q} * PW'(beta_q)) >> KW)
                 + AW'((({{(KW+FRAC){1'b0}}, d} * HW'(theta_q)) << FRAC) >> KW);
    assign nxt = (|sum_w[AW-1:SW]) ? {SW{1'b1}} : sum_w[SW-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n)            est_q <= '0;
      else if (hit)          est_q <= {hot, {FRAC{1'b0}}};
      else if (egy_valid[c]) est_q <= nxt;
    end
    assign chan_est[c*SW +: SW] = est_q;

    for (genvar k = 0; k < NDIMM; k++) begin : g_dimm
      logic [RW-1:0] rk_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                            rk_q <= '0;
        else if (hit && rank_dimm == IW'(k))   rk_q <= rank_wdata;
      end
      assign rank_temp[(c*NDIMM+k)*RW +: RW] = rk_q;
    end
  end
endmodule

// File: rtl/dram_temp_filter_chk.sv
module dram_temp_filter_chk #(
  parameter int NCH = 3, parameter int NDIMM = 3, parameter int NRANK = 4,
  parameter int TW = 8, parameter int FRAC = 8, parameter int KW = 10, parameter int IW = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cfg_we,
  input logic [31:0]                   cfg_wdata,
  input logic [31:0]                   cfg_rdata,
  input logic                          rank_we,
  input logic [IW-1:0]                 rank_chan,
  input logic [IW-1:0]                 rank_dimm,
  input logic [NCH-1:0]                egy_valid,
  input logic [NCH*(TW+FRAC)-1:0]      chan_est,
  input logic [NCH*NDIMM*NRANK*TW-1:0] rank_temp,
  input logic                          idx_err
);
  localparam int SW = TW + FRAC;
  logic bad;
  assign bad = rank_we && ((int'(rank_chan) >= NCH) || (int'(rank_dimm) >= NDIMM));

  assert_cfg_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == {{(32-2*KW){1'b0}}, $past(cfg_wdata[2*KW-1:0])});

  assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));

  assert_err_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> idx_err);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |=> idx_err);

  assert_bad_no_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> $stable(rank_temp));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    assert_est_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!egy_valid[c] && !(rank_we && int'(rank_chan) == c)) |=> $stable(chan_est[c*SW +: SW]));
  end
endmodule

bind dram_temp_filter dram_temp_filter_chk #(
  .NCH(NCH), .NDIMM(NDIMM), .NRANK(NRANK), .TW(TW), .FRAC(FRAC), .KW(KW), .IW(IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .rank_we(rank_we), .rank_chan(rank_chan), .rank_dimm(rank_dimm), .egy_valid(egy_valid),
  .chan_est(chan_est), .rank_temp(rank_temp), .idx_err(idx_err)
);

// File: tb/tb_dram_temp_filter.sv
module tb_dram_temp_filter;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        rank_we = 0;
  logic [2:0]  rank_chan = 0, rank_dimm = 0;
  logic [31:0] rank_wdata = 0;
  logic [2:0]  egy_valid = 0;
  logic [47:0] egy_delta = 0;
  logic [47:0] chan_est;
  logic [287:0] rank_temp;
  logic        idx_err;

  dram_temp_filter dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  string tag = "R2";
  longint m_est[3];
  logic [31:0] m_rank[3][3];
  longint m_beta, m_theta;
  bit m_err;

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    longint nx[3];
    bit ok;
    if (!rst_n) begin
      m_beta = 1023; m_theta = 0; m_err = 0;
      for (int c = 0; c < 3; c++) begin
        m_est[c] = 0;
        for (int k = 0; k < 3; k++) m_rank[c][k] = 0;
      end
      return;
    end
    ok = (rank_chan < 3) && (rank_dimm < 3);
    for (int c = 0; c < 3; c++) begin
      nx[c] = m_est[c];
      if (rank_we && ok && rank_chan == c) begin
        longint mx = 0;
        for (int r = 0; r < 4; r++) if (rank_wdata[8*r +: 8] > mx) mx = rank_wdata[8*r +: 8];
        nx[c] = mx * 256;
      end else if (egy_valid[c]) begin
        longint dl = egy_delta[16*c +: 16];
        nx[c] = (m_beta * m_est[c]) / 1024 + (m_theta * dl * 256) / 1024;
        if (nx[c] > 65535) nx[c] = 65535;
      end
    end
    if (rank_we && ok) m_rank[rank_chan][rank_dimm] = rank_wdata;
    if (rank_we && !ok) m_err = 1;
    for (int c = 0; c < 3; c++) m_est[c] = nx[c];
    if (cfg_we) begin
      m_beta  = cfg_wdata[9:0];
      m_theta = cfg_wdata[19:10];
    end
  endtask

  task automatic compare();
    chk("cfg_rdata (R1)", cfg_rdata, {m_theta[9:0], m_beta[9:0]});
    for (int c = 0; c < 3; c++) begin
      chk($sformatf("chan_est[%0d] (R3)", c), chan_est[16*c +: 16], m_est[c]);
      for (int k = 0; k < 3; k++)
        chk($sformatf("rank_temp[%0d][%0d] (R7)", c, k), rank_temp[32*(3*c+k) +: 32], m_rank[c][k]);
    end
    chk("idx_err (R9)", idx_err, m_err);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    compare();
    cfg_we = 0; rank_we = 0; egy_valid = 0;
  endtask

  task automatic energy(logic [2:0] v, logic [15:0] d0, logic [15:0] d1, logic [15:0] d2);
    egy_valid = v; egy_delta = {d2, d1, d0};
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R6 watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tag = "R2";
    repeat (3) tick();
    rst_n = 1;
    tick();
    tag = "R2"; chk("reset beta readback", cfg_rdata, 32'h3FF);

    tag = "R1";
    cfg_we = 1; cfg_wdata = {12'hABC, 10'h200, 10'h300};
    tick();
    chk("reserved bits zero", cfg_rdata[31:20], 0);

    tag = "R3";
    for (int i = 0; i < 6; i++) begin
      energy(3'b011, 16'd100 + 16'(i * 37), 16'd2000, 16'd0);
      tick();
    end
    tag = "R5";
    rst_n = 0; tick(); rst_n = 1;
    cfg_we = 1; cfg_wdata = {12'h000, 10'h155, 10'h3F0}; tick();
    for (int i = 0; i < 5; i++) begin
      energy(3'b111, 16'd900, 16'd900, 16'd900);
      tick();
    end
    chk("channels equal", chan_est[15:0], chan_est[31:16]);
    chk("channels equal", chan_est[47:32], chan_est[15:0]);

    tag = "R6";
    repeat (4) tick();

    tag = "R4";
    cfg_we = 1; cfg_wdata = 32'h000F_FFFF; tick();
    energy(3'b100, 16'h0, 16'h0, 16'hFFFF); tick();
    energy(3'b100, 16'h0, 16'h0, 16'hFFFF); tick();
    chk("saturated", chan_est[47:32], 16'hFFFF);

    tag = "R7";
    for (int c = 0; c < 3; c++)
      for (int k = 0; k < 3; k++) begin
        rank_we = 1; rank_chan = 3'(c); rank_dimm = 3'(k);
        rank_wdata = 32'h1020_3040 + 32'(c * 16 + k);
        tick();
      end

    tag = "R8";
    rank_we = 1; rank_chan = 1; rank_dimm = 2; rank_wdata = 32'h1040_2005;
    energy(3'b111, 16'd300, 16'd300, 16'd300);
    tick();
    chk("est seeded from hottest rank", chan_est[31:16], 16'h4000);
    energy(3'b010, 16'd0, 16'd50, 16'd0); tick();

    tag = "R9";
    rank_we = 1; rank_chan = 3; rank_dimm = 0; rank_wdata = 32'hFFFF_FFFF; tick();
    chk("err set", idx_err, 1);
    rank_we = 1; rank_chan = 0; rank_dimm = 3; rank_wdata = 32'hEEEE_EEEE; tick();
    rank_we = 1; rank_chan = 7; rank_dimm = 7; rank_wdata = 32'hDDDD_DDDD; tick();
    repeat (2) tick();
    chk("err sticky", idx_err, 1);

    tag = "R10";
    cfg_we = 1; cfg_wdata = {12'hFFF, 10'h010, 10'h200};
    energy(3'b111, 16'd4000, 16'd10, 16'd777);
    tick();
    energy(3'b111, 16'd4000, 16'd10, 16'd777);
    tick();

    tag = "R2";
    rst_n = 0; tick(); rst_n = 1; tick();
    chk("err cleared by reset", idx_err, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule